// File: doc/BRIEF.md
# CAN Test-Mode Pin Control

This block sits between a CAN protocol core and the chip's CAN bus pins and gives test software direct control of those pins. A 32-bit test word is held behind a plain register port. It chooses what drives the transmit pin:
- the core's bit, refreshed once per bit time,
- the core's sample-point strobe, so bit timing can be watched on a scope,
- a forced dominant level,
- a forced recessive level.

Another bit of the word closes an internal loop so that the core hears its own transmit data. In that mode the bus is cut off from the core's receive input.

The same word forces two auxiliary output lines high, OR-ed with their functional drivers. It also reads back the live level of those two lines and of the synchronized receive pin. Writes take effect only while the protection input is high. A write made while protection is locked is dropped and raises a one-cycle error pulse.

The register port and all pins are plain control and status signals. There is no valid/ready stream at the edge of this block, so there is no back-pressure: each write is handled in the cycle it is presented, and the readback is always valid.

Top module: `can_testpin_ctrl`

## Requirements
- R1: After reset, bits 6:0 of the test word read 0, `wr_err` is 0, and `can_tx_pin` is recessive (1).
- R2: Bits 31:8 of `reg_rdata` always read 0, and writing ones to them has no effect.
- R3: A write (`reg_wr` high at a rising edge) updates the word only while `prot_unlock` is high. Otherwise the word is unchanged and `wr_err` is high for exactly the following cycle.
- R4: With transmit select (bits 6:5) = 00, `can_tx_pin` takes the value of `core_tx` sampled at each rising edge where `core_bit_end` is high, and holds it at every other edge.
- R5: With transmit select = 01, `can_tx_pin` equals `core_sample` in the same cycle.
- R6: Transmit select = 10 drives `can_tx_pin` to 0 (dominant). Transmit select = 11 drives it to 1 (recessive).
- R7: With bit 4 set (loop-back), `core_rx` equals `core_tx` in the same cycle, and `can_rx_pin` has no effect on it.
- R8: With bit 4 clear, `core_rx` follows `can_rx_pin` after two rising edges of synchronization, and the synchronizer resets to 1.
- R9: Bit 7 reads the synchronized receive-pin level, whether or not loop-back is on, and writes to bit 7 are ignored.
- R10: Bit 0 forces `aux_mux_o` high and bit 1 forces `aux_tx_o` high. Each output is the OR of its force bit and its functional input (`aux_mux_fn`, `aux_tx_fn`).
- R11: Bits 2 and 3 read the current levels of `aux_mux_o` and `aux_tx_o` respectively, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the test word |
| reg_wdata | input | 32 | Write data |
| prot_unlock | input | 1 | Write protection open when high |
| reg_rdata | output | 32 | Current test word readback |
| wr_err | output | 1 | One-cycle pulse after a blocked write |
| core_tx | input | 1 | Transmit bit from the protocol core |
| core_sample | input | 1 | Sample-point strobe from the core |
| core_bit_end | input | 1 | End-of-bit-time strobe from the core |
| core_rx | output | 1 | Receive bit delivered to the core |
| aux_mux_fn | input | 1 | Functional driver of auxiliary line A |
| aux_tx_fn | input | 1 | Functional driver of auxiliary line B |
| aux_mux_o | output | 1 | Auxiliary line A |
| aux_tx_o | output | 1 | Auxiliary line B |
| can_rx_pin | input | 1 | Bus receive pin |
| can_tx_pin | output | 1 | Bus transmit pin |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a two-stage receive synchronizer and a recessive idle level on the transmit pin. The full-width word makes every reserved bit reachable for the read-as-zero check. The two-stage depth lets the bench pin down the exact edge at which a receive-pin change reaches `core_rx` and bit 7. The recessive idle level fixes the expected transmit-pin value before the first end-of-bit strobe.

// File: rtl/can_tp_pkg.sv
package can_tp_pkg;

  typedef enum logic [1:0] {
    TXS_CORE   = 2'b00,
    TXS_SAMPLE = 2'b01,
    TXS_DOM    = 2'b10,
    TXS_REC    = 2'b11
  } txsel_e;

  localparam int FRC_MUX_B = 0;
  localparam int FRC_TX_B  = 1;
  localparam int MON_MUX_B = 2;
  localparam int MON_TX_B  = 3;
  localparam int LPBK_B    = 4;
  localparam int TXSEL_LSB = 5;
  localparam int RXLVL_B   = 7;
  localparam int USED_W    = 8;

  typedef struct packed {
    txsel_e txsel;
    logic   lpbk;
    logic   frc_tx;
    logic   frc_mux;
  } tp_cfg_t;

endpackage

// File: rtl/tp_cfg_reg.sv
module tp_cfg_reg
  import can_tp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              unlock,
  output tp_cfg_t           cfg,
  output logic              wr_err
);

  // Bits that no write can change: reserved, the monitors and the receive level.
  logic unused_wbits;
  assign unused_wbits = ^{wdata[DATA_W-1:USED_W], wdata[RXLVL_B],
                          wdata[MON_TX_B], wdata[MON_MUX_B]};

  logic accept;
  assign accept = wr && unlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '{txsel: TXS_CORE, lpbk: 1'b0, frc_tx: 1'b0, frc_mux: 1'b0};
      wr_err <= 1'b0;
    end else begin
      wr_err <= wr && !unlock;
      if (accept) begin
        cfg.txsel   <= txsel_e'(wdata[TXSEL_LSB +: 2]);
        cfg.lpbk    <= wdata[LPBK_B];
        cfg.frc_tx  <= wdata[FRC_TX_B];
        cfg.frc_mux <= wdata[FRC_MUX_B];
      end
    end
  end

endmodule

// File: rtl/tp_rx_sync.sv
module tp_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= RST_VAL;
        else        stg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/tp_tx_sel.sv
module tp_tx_sel
  import can_tp_pkg::*;
#(
  parameter logic TX_IDLE = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  txsel_e txsel,
  input  logic   core_tx,
  input  logic   core_sample,
  input  logic   core_bit_end,
  output logic   pin
);

  // The bit-time latch keeps running in every mode.
  // Returning to core mode therefore shows the current bit at once.
  logic bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            bit_q <= TX_IDLE;
    else if (core_bit_end) bit_q <= core_tx;
  end

  always_comb begin
    unique case (txsel)
      TXS_CORE:   pin = bit_q;
      TXS_SAMPLE: pin = core_sample;
      TXS_DOM:    pin = 1'b0;
      TXS_REC:    pin = 1'b1;
      default:    pin = TX_IDLE;
    endcase
  end

endmodule

// File: rtl/can_testpin_ctrl.sv
module can_testpin_ctrl
  import can_tp_pkg::*;
#(
  parameter int   DATA_W      = 32,
  parameter int   SYNC_STAGES = 2,
  parameter logic TX_IDLE     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              prot_unlock,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wr_err,
  input  logic              core_tx,
  input  logic              core_sample,
  input  logic              core_bit_end,
  output logic              core_rx,
  input  logic              aux_mux_fn,
  input  logic              aux_tx_fn,
  output logic              aux_mux_o,
  output logic              aux_tx_o,
  input  logic              can_rx_pin,
  output logic              can_tx_pin
);

  tp_cfg_t cfg;
  logic    rx_s;

  tp_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .unlock (prot_unlock),
    .cfg    (cfg),
    .wr_err (wr_err)
  );

  tp_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxs (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (can_rx_pin),
    .q     (rx_s)
  );

  tp_tx_sel #(.TX_IDLE(TX_IDLE)) u_txs (
    .clk          (clk),
    .rst_n        (rst_n),
    .txsel        (cfg.txsel),
    .core_tx      (core_tx),
    .core_sample  (core_sample),
    .core_bit_end (core_bit_end),
    .pin          (can_tx_pin)
  );

  assign aux_mux_o = aux_mux_fn | cfg.frc_mux;
  assign aux_tx_o  = aux_tx_fn  | cfg.frc_tx;
  assign core_rx   = cfg.lpbk ? core_tx : rx_s;

  always_comb begin
    reg_rdata                  = '0;
    reg_rdata[FRC_MUX_B]       = cfg.frc_mux;
    reg_rdata[FRC_TX_B]        = cfg.frc_tx;
    reg_rdata[MON_MUX_B]       = aux_mux_o;
    reg_rdata[MON_TX_B]        = aux_tx_o;
    reg_rdata[LPBK_B]          = cfg.lpbk;
    reg_rdata[TXSEL_LSB +: 2]  = cfg.txsel;
    reg_rdata[RXLVL_B]         = rx_s;
  end

endmodule

// File: rtl/tp_chk.sv
module tp_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              prot_unlock,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              wr_err,
  input logic              core_tx,
  input logic              core_sample,
  input logic              core_bit_end,
  input logic              core_rx,
  input logic              aux_mux_fn,
  input logic              aux_tx_fn,
  input logic              aux_mux_o,
  input logic              aux_tx_o,
  input logic              can_tx_pin
);

  logic [1:0] tsel;
  assign tsel = reg_rdata[6:5];

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:8] == '0);

  // R3
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !prot_unlock) |=> ($stable(reg_rdata[6:4]) && $stable(reg_rdata[1:0])));

  // R3
  wr_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(reg_wr && !prot_unlock));

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tsel == 2'b00 && $past(tsel) == 2'b00 && !$past(core_bit_end)) |-> $stable(can_tx_pin));

  // R5
  sample_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tsel == 2'b01) |-> (can_tx_pin == core_sample));

  // R6
  force_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tsel == 2'b10) |-> !can_tx_pin);

  // R6
  force_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tsel == 2'b11) |-> can_tx_pin);

  // R7
  loopback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4] |-> (core_rx == core_tx));

  // R10
  aux_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((aux_mux_fn || reg_rdata[0]) |-> aux_mux_o) and ((aux_tx_fn || reg_rdata[1]) |-> aux_tx_o));

  // R11
  aux_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[2] == aux_mux_o) && (reg_rdata[3] == aux_tx_o));

endmodule

bind can_testpin_ctrl tp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .prot_unlock  (prot_unlock),
  .reg_rdata    (reg_rdata),
  .wr_err       (wr_err),
  .core_tx      (core_tx),
  .core_sample  (core_sample),
  .core_bit_end (core_bit_end),
  .core_rx      (core_rx),
  .aux_mux_fn   (aux_mux_fn),
  .aux_tx_fn    (aux_tx_fn),
  .aux_mux_o    (aux_mux_o),
  .aux_tx_o     (aux_tx_o),
  .can_tx_pin   (can_tx_pin)
);

// File: tb/tb_can_testpin_ctrl.sv
module tb_can_testpin_ctrl;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic          prot_unlock = 1'b1;
  logic [DW-1:0] reg_rdata;
  logic          wr_err;
  logic          core_tx = 1'b1;
  logic          core_sample = 1'b0;
  logic          core_bit_end = 1'b0;
  logic          core_rx;
  logic          aux_mux_fn = 1'b0;
  logic          aux_tx_fn = 1'b0;
  logic          aux_mux_o;
  logic          aux_tx_o;
  logic          can_rx_pin = 1'b1;
  logic          can_tx_pin;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  can_testpin_ctrl dut (.*);

  // Vector: {txsel[1:0], force[1:0] (tx,mux), fn[1:0] (tx,mux), sample, expected pin}
  localparam logic [7:0] VEC [8] = '{
    8'b01000011, 8'b01010000, 8'b10100010, 8'b11001101,
    8'b10000100, 8'b11111011, 8'b01100111, 8'b10011000
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [DW-1:0] d, input logic unl);
    @(negedge clk);
    reg_wr      = 1'b1;
    reg_wdata   = d;
    prot_unlock = unl;
    @(negedge clk);
    reg_wr      = 1'b0;
    prot_unlock = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state; bit 7 holds the recessive synchronizer reset
    check("R1 word", reg_rdata, 32'h80);
    check("R1 wr_err", {31'd0, wr_err}, 0);
    check("R1 tx pin", {31'd0, can_tx_pin}, 1);

    // R5 R6 R10 R11 table walk
    foreach (VEC[i]) begin
      logic [1:0] ts, fr, fn;
      ts = VEC[i][7:6];
      fr = VEC[i][5:4];
      fn = VEC[i][3:2];
      wr_word({25'd0, ts, 3'b000, fr}, 1'b1);
      aux_tx_fn   = fn[1];
      aux_mux_fn  = fn[0];
      core_sample = VEC[i][1];
      #1;
      check(ts == 2'b01 ? "R5 pin" : "R6 pin", {31'd0, can_tx_pin}, {31'd0, VEC[i][0]});
      check("R10 aux", {30'd0, aux_tx_o, aux_mux_o}, {30'd0, fr | fn});
      check("R11 monitors", {30'd0, reg_rdata[3:2]}, {30'd0, fr | fn});
      check("R3 accepted", {25'd0, reg_rdata[6:4], 2'b00, reg_rdata[1:0]}, {25'd0, ts, 1'b0, 2'b00, fr});
    end
    aux_tx_fn   = 1'b0;
    aux_mux_fn  = 1'b0;
    core_sample = 1'b0;

    // R2 reserved bits ignored; bits 0,1,4 written; monitors follow forcing
    wr_word(32'hFFFF_FF13, 1'b1);
    check("R2 readback", reg_rdata, 32'h9F);

    // R3 blocked write
    wr_word(32'h0, 1'b0);
    check("R3 blocked word", reg_rdata, 32'h9F);
    check("R3 err pulse", {31'd0, wr_err}, 1);
    @(negedge clk);
    check("R3 err one cycle", {31'd0, wr_err}, 0);
    wr_word(32'h0, 1'b1);
    check("R3 unlocked write", reg_rdata, 32'h80);
    check("R3 no err", {31'd0, wr_err}, 0);

    // R11 monitor bits not writable
    wr_word(32'h0C, 1'b1);
    check("R11 monitor write ignored", reg_rdata, 32'h80);

    // R8 synchronizer latency
    can_rx_pin = 1'b0;
    @(negedge clk);
    check("R8 after one edge", {31'd0, core_rx}, 1);
    @(negedge clk);
    check("R8 after two edges", {31'd0, core_rx}, 0);
    check("R9 rx level", {31'd0, reg_rdata[7]}, 0);
    wr_word(32'h80, 1'b1);
    check("R9 write ignored", {31'd0, reg_rdata[7]}, 0);

    // R7 loop-back with the pin held dominant
    wr_word(32'h10, 1'b1);
    core_tx = 1'b1;
    #1;
    check("R7 loop high", {31'd0, core_rx}, 1);
    check("R9 pin still read", {31'd0, reg_rdata[7]}, 0);
    core_tx = 1'b0;
    #1;
    check("R7 loop low", {31'd0, core_rx}, 0);
    wr_word(32'h00, 1'b1);
    can_rx_pin = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 loop off", {31'd0, core_rx}, 1);

    // R4 core mode: latched only at end-of-bit strobes
    check("R4 before strobe", {31'd0, can_tx_pin}, 1);
    core_tx = 1'b0;
    core_bit_end = 1'b1;
    @(negedge clk);
    check("R4 latched dominant", {31'd0, can_tx_pin}, 0);
    core_bit_end = 1'b0;
    core_tx = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 hold without strobe", {31'd0, can_tx_pin}, 0);
    core_bit_end = 1'b1;
    @(negedge clk);
    check("R4 latched recessive", {31'd0, can_tx_pin}, 1);
    core_bit_end = 1'b0;

    finish_run();
  end

endmodule